// File: doc/BRIEF.md
# Test-Mode Persistence Controller

This block keeps a device held in clamp-style test mode across a sequence of scan instructions, including any instruction that is not a test instruction and is loaded between two test instructions. A two-state machine holds either "persistence off" or "persistence on". The state feeds the chip's test-mode control, ORed with the current clamp or test-instruction decode. Once the block is on, only three things take it off:

- an explicit release instruction;
- a one-bit escape flag armed beforehand and then consumed as the bypass instruction is loaded;
- a hardware reset, from the test reset pin or from power-on.

Passing through the TAP's logic-reset state does not clear it.

A two-bit scan register belongs to the controller. It is selected by the hold, release and status instructions. It reports the state and gives read and write access to the escape flag. The TAP controller and the instruction decoder sit outside the block. They supply one-hot instruction flags, an Update-IR indication and the data-register capture, shift and update strobes.

Top module: `tmp_persist_ctrl`

## Requirements
- R1: While `trst_n` or `por_n` is low, the state is off, the escape flag is 0, `ch_rst_n` is 0 and `tdo` is 0. All of this applies at once, with no clock edge.
- R2: At a rising `tck` with `ins_hold` high, the state becomes on. `ins_hold` wins over every other condition.
- R3: At a rising `tck` with `ins_release` high and `ins_hold` low, the state becomes off.
- R4: At a rising `tck` with `ins_bypass` high, `tap_upd_ir` high and the escape flag at 1, the state becomes off. With the escape flag at 0, the same event leaves the state unchanged.
- R5: No other condition changes the state. This includes `tap_upd_ir` with any instruction other than bypass, the status instruction, the data strobes, and the TAP passing through logic-reset, which never asserts Update-IR.
- R6: The register is selected when any of `ins_hold`, `ins_release` or `ins_status` is high.
  - A selected capture loads bit 1 with the state (1 = on) and bit 0 with the escape flag.
  - A selected shift moves `tdi` into bit 1 and bit 1 into bit 0.
  - `tdo` always shows bit 0.
  - Capture takes precedence over shift.
- R7: A selected `dr_update` copies bit 0 of the shift stage into the escape flag. The escape flag changes in no other way except reset.
- R8: `test_mode` equals the state ORed with `ins_clamp`. `ch_rst_n` is high only when the state is on and no hardware reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset pin, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ins_hold | input | 1 | Hold instruction is active |
| ins_release | input | 1 | Release instruction is active |
| ins_status | input | 1 | Status instruction is active |
| ins_bypass | input | 1 | Bypass instruction is in the instruction register |
| ins_clamp | input | 1 | Decode of any clamp/test-mode instruction |
| tap_upd_ir | input | 1 | TAP is in Update-IR |
| dr_capture | input | 1 | Data-register capture strobe |
| dr_shift | input | 1 | Data-register shift strobe |
| dr_update | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial data in |
| persist_on | output | 1 | Controller state, 1 = persistence on |
| test_mode | output | 1 | Force test mode to the chip |
| ch_rst_n | output | 1 | Clamp-hold reset, low while persistence is off |
| tdo | output | 1 | Serial data out, bit 0 of the register |

## Verification
The block has no size parameters. Its register length and bit positions are fixed package constants, so the bench builds the single default configuration. That configuration reaches every case: every pairing of state and escape flag with every instruction flag and every strobe, including hold and release asserted together. Random asynchronous resets land in the middle of scans and also while the escape flag is armed.

// File: rtl/tmp_pkg.sv
package tmp_pkg;
    localparam int DR_W     = 2;
    localparam int ESC_POS  = 0;
    localparam int STAT_POS = 1;

    typedef enum logic {
        PERSIST_OFF = 1'b0,
        PERSIST_ON  = 1'b1
    } pstate_e;

    typedef struct packed {
        pstate_e st;
    } fsm_regs_t;

    typedef struct packed {
        logic [DR_W-1:0] sh;
        logic            esc;
    } dr_regs_t;
endpackage

// File: rtl/tmp_fsm.sv
module tmp_fsm
    import tmp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold,
    input  logic    rel,
    input  logic    byp,
    input  logic    upd_ir,
    input  logic    esc,
    output pstate_e state
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (hold) begin
            r_d.st = PERSIST_ON;
        end else if (rel) begin
            r_d.st = PERSIST_OFF;
        end else if (byp && upd_ir && esc) begin
            r_d.st = PERSIST_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PERSIST_OFF};
        else        r_q <= r_d;
    end

    assign state = r_q.st;
endmodule

// File: rtl/tmp_dr.sv
module tmp_dr
    import tmp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel,
    input  logic    capture,
    input  logic    shift,
    input  logic    update,
    input  logic    tdi,
    input  pstate_e state,
    output logic    esc,
    output logic    tdo
);
    dr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sel && capture) begin
            r_d.sh[STAT_POS] = (state == PERSIST_ON);
            r_d.sh[ESC_POS]  = r_q.esc;
        end else if (sel && shift) begin
            r_d.sh = {tdi, r_q.sh[DR_W-1:1]};
        end
        if (sel && update) begin
            r_d.esc = r_q.sh[ESC_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign esc = r_q.esc;
    assign tdo = r_q.sh[0];
endmodule

// File: rtl/tmp_persist_ctrl.sv
module tmp_persist_ctrl
    import tmp_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic por_n,
    input  logic ins_hold,
    input  logic ins_release,
    input  logic ins_status,
    input  logic ins_bypass,
    input  logic ins_clamp,
    input  logic tap_upd_ir,
    input  logic dr_capture,
    input  logic dr_shift,
    input  logic dr_update,
    input  logic tdi,
    output logic persist_on,
    output logic test_mode,
    output logic ch_rst_n,
    output logic tdo
);
    logic    hw_rst_n;
    logic    dr_sel;
    logic    esc_bit;
    pstate_e state;

    assign hw_rst_n = trst_n & por_n;
    assign dr_sel   = ins_hold | ins_release | ins_status;

    tmp_fsm u_fsm (
        .clk    (tck),
        .rst_n  (hw_rst_n),
        .hold   (ins_hold),
        .rel    (ins_release),
        .byp    (ins_bypass),
        .upd_ir (tap_upd_ir),
        .esc    (esc_bit),
        .state  (state)
    );

    tmp_dr u_dr (
        .clk     (tck),
        .rst_n   (hw_rst_n),
        .sel     (dr_sel),
        .capture (dr_capture),
        .shift   (dr_shift),
        .update  (dr_update),
        .tdi     (tdi),
        .state   (state),
        .esc     (esc_bit),
        .tdo     (tdo)
    );

    assign persist_on = (state == PERSIST_ON);
    assign test_mode  = persist_on | ins_clamp;
    assign ch_rst_n   = hw_rst_n & persist_on;
endmodule

// File: rtl/tmp_persist_chk.sv
module tmp_persist_chk (
    input logic tck,
    input logic trst_n,
    input logic por_n,
    input logic ins_hold,
    input logic ins_release,
    input logic ins_status,
    input logic ins_bypass,
    input logic tap_upd_ir,
    input logic dr_capture,
    input logic esc_bit,
    input logic persist_on,
    input logic tdo
);
    logic rst_n;
    assign rst_n = trst_n & por_n;

    // R2
    hold_sets_chk: assert property (@(posedge tck) disable iff (!rst_n)
        ins_hold |=> persist_on);

    // R3
    release_clears_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (ins_release && !ins_hold) |=> !persist_on);

    // R4
    escape_clears_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (ins_bypass && tap_upd_ir && esc_bit && !ins_hold && !ins_release) |=> !persist_on);

    // R5
    state_holds_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (!ins_hold && !ins_release && !(ins_bypass && tap_upd_ir && esc_bit))
        |=> $stable(persist_on));

    // R6
    capture_esc_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (dr_capture && (ins_hold || ins_release || ins_status)) |=> (tdo == $past(esc_bit)));
endmodule

bind tmp_persist_ctrl tmp_persist_chk u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .por_n       (por_n),
    .ins_hold    (ins_hold),
    .ins_release (ins_release),
    .ins_status  (ins_status),
    .ins_bypass  (ins_bypass),
    .tap_upd_ir  (tap_upd_ir),
    .dr_capture  (dr_capture),
    .esc_bit     (esc_bit),
    .persist_on  (persist_on),
    .tdo         (tdo)
);

// File: tb/sim_tmp_persist_ctrl.sv
module sim_tmp_persist_ctrl;
    logic tck = 1'b0;
    always #2 tck = ~tck;

    logic trst_n, por_n, ins_hold, ins_release, ins_status, ins_bypass, ins_clamp;
    logic tap_upd_ir, dr_capture, dr_shift, dr_update, tdi;
    logic persist_on, test_mode, ch_rst_n, tdo;

    int checks = 0;
    int fails  = 0;

    bit       m_st, m_esc;
    bit [1:0] m_sh;

    tmp_persist_ctrl u0 (.*);

    task automatic chk(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic bit next_st(bit st, bit esc, bit h, bit r, bit b, bit u);
        if (h)                return 1'b1;
        else if (r)           return 1'b0;
        else if (b && u && esc) return 1'b0;
        else                  return st;
    endfunction

    task automatic check_outs(input string st_req);
        bit rst_now;
        rst_now = !(trst_n && por_n);
        chk(persist_on, m_st, st_req);
        chk(test_mode, m_st | ins_clamp, "R8 test_mode");
        chk(ch_rst_n, m_st & !rst_now, "R8 ch_rst_n");
        chk(tdo, m_sh[0], "R6 tdo");
    endtask

    task automatic step(input bit h, r, s, b, c, u, cap, sh, up, d, input string st_req);
        bit sel;
        bit [1:0] nsh;
        bit nesc;
        ins_hold = h; ins_release = r; ins_status = s; ins_bypass = b; ins_clamp = c;
        tap_upd_ir = u; dr_capture = cap; dr_shift = sh; dr_update = up; tdi = d;
        sel  = h | r | s;
        nsh  = m_sh;
        nesc = m_esc;
        if (sel && cap)     nsh = {m_st, m_esc};
        else if (sel && sh) nsh = {d, m_sh[1]};
        if (sel && up)      nesc = m_sh[0];
        m_st  = next_st(m_st, m_esc, h, r, b, u);
        m_sh  = nsh;
        m_esc = nesc;
        @(posedge tck);
        @(negedge tck);
        check_outs(st_req);
    endtask

    task automatic hw_reset(input bit use_por);
        if (use_por) por_n = 1'b0; else trst_n = 1'b0;
        m_st = 0; m_esc = 0; m_sh = 0;
        #1;
        chk(persist_on, 1'b0, "R1 state");
        chk(ch_rst_n, 1'b0, "R1 ch_rst_n");
        chk(tdo, 1'b0, "R1 tdo");
        @(negedge tck);
        trst_n = 1'b1; por_n = 1'b1;
    endtask

    initial begin
        #80000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        trst_n = 1'b0; por_n = 1'b0;
        {ins_hold, ins_release, ins_status, ins_bypass, ins_clamp} = '0;
        {tap_upd_ir, dr_capture, dr_shift, dr_update, tdi} = '0;
        m_st = 0; m_esc = 0; m_sh = 0;
        @(negedge tck);
        #1;
        chk(persist_on, 1'b0, "R1 reset state");
        chk(ch_rst_n, 1'b0, "R1 reset ch_rst_n");
        @(negedge tck);
        trst_n = 1'b1; por_n = 1'b1;

        // directed corners: argument order h r s b c u cap sh up tdi
        step(1,0,0,0,1,0,0,0,0,0, "R2 hold");
        step(0,0,0,0,0,1,0,0,0,0, "R5 upd_ir no bypass");
        step(0,0,0,1,0,1,0,0,0,0, "R4 bypass esc=0 stays");
        step(0,0,1,0,0,0,1,0,0,0, "R6 capture");
        step(0,0,1,0,0,0,0,1,0,1, "R6 shift1");
        step(0,0,1,0,0,0,0,1,0,1, "R6 shift2");
        step(0,0,1,0,0,0,0,0,1,0, "R7 update arms esc");
        step(0,0,0,0,0,0,0,0,1,0, "R7 unselected update");
        step(0,0,1,0,0,0,1,0,0,0, "R7 esc readback");
        step(0,0,0,1,0,0,0,0,0,0, "R5 bypass no upd_ir");
        step(1,1,0,0,0,0,0,0,0,0, "R2 hold over release");
        step(0,0,0,1,0,1,0,0,0,0, "R4 escape");
        step(1,0,0,0,0,0,0,0,0,0, "R2 hold again");
        step(0,1,0,0,0,0,0,0,0,0, "R3 release");
        step(1,0,0,0,0,0,0,0,0,0, "R2 hold before reset");
        hw_reset(1'b0);
        step(0,0,0,0,0,0,0,0,0,0, "R1 after trst");

        for (int i = 0; i < 4000; i++) begin
            int ins, stb;
            bit h, r, s, b, u, cap, sh, up;
            ins = $urandom_range(0, 9);
            stb = $urandom_range(0, 3);
            h = (ins == 0); r = (ins == 1); s = (ins >= 2 && ins <= 4);
            b = (ins >= 5 && ins <= 7);
            if (ins == 9) begin h = 1; r = ($urandom_range(0, 1) == 1); end
            u   = ($urandom_range(0, 2) == 0);
            cap = (stb == 1); sh = (stb == 2); up = (stb == 3);
            if ($urandom_range(0, 199) == 0) hw_reset($urandom_range(0, 1) == 1);
            step(h, r, s, b, $urandom_range(0, 1) == 1, u, cap, sh, up,
                 $urandom_range(0, 1) == 1,
                 h ? "R2 rand" : r ? "R3 rand" : (b && u) ? "R4 rand" : "R5 rand");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule